// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block holds one pending-request bit for each vector slot of a small processor. It chooses at most one slot to hand to the core. Each slot watches one of two raw event lines, either an external pin or a timer underflow pulse. A per-slot select bit picks the line, and a per-slot polarity bit picks which transition counts. A pending bit is set when the selected, polarity-adjusted level rises. That level can also rise because software changed the polarity or the line select, so a reconfiguration can raise a request that no real event caused. Software that wants to avoid this disables the slot, reconfigures it, clears the pending bit and then enables the slot again.

The core pulses `sampleStrobe` on the clock where an instruction completes. Acceptance is decided only on that clock. A slot can win only if its pending bit and its enable bit are both 1 and the global mask flag is 0. The lowest-numbered eligible slot wins. The winner's pending bit is cleared, the mask flag is set so that no nested request is taken, and the slot number is reported as a binary vector index with a one-cycle valid pulse. Slots that lose keep their pending bits and compete again at the next strobe. A small register port gives software access to the pending, enable, polarity, line-select and mask state.

Top module: `irq_req_ctrl`

## Requirements
- R1: A clock with `rst` high sets `accValid` to 0, clears the pending, enable, polarity and line-select registers, and sets the mask flag to 1.
- R2: For slot i, the effective level is (lineSel[i] ? srcB[i] : srcA[i]) XOR polarity[i]. Polarity 0 means a rising input edge and 1 means a falling input edge. On each clock where this level is 1 and was 0 at the previous clock, pending[i] becomes 1. The level held before the first clock after reset counts as 0.
- R3: When a write to the polarity register or the line-select register makes a slot's effective level go from 0 to 1, that slot's pending bit is set one clock after the write takes effect. No real input edge is needed.
- R4: A slot is accepted only on a clock where `sampleStrobe` is 1, pending[i] is 1, enable[i] is 1 and the mask flag is 0. On any other clock, `accValid` is 0 in the following cycle.
- R5: When several slots are eligible, the lowest index wins. `accValid` is 1 for exactly the one cycle after the accepting clock, and `accVec` then holds the winning index in binary.
- R6: On acceptance, the winner's pending bit is cleared and the mask flag becomes 1, even if software writes 0 to the flag on the same clock. Pending bits of slots that lose stay unchanged.
- R7: Writing address 0 clears each pending bit whose data bit is 0 and leaves bits written with 1 unchanged. A hardware set on the same clock overrides both this clear and an acceptance clear.
- R8: Register map (`rwAddr`): 0 = pending, 1 = enable, 2 = polarity, 3 = line select, and 4 = mask flag in bit 0. Writes to addresses 1 to 3 replace the whole register. A write to address 4 loads bit 0. Addresses 5 to 7 read as 0 and ignore writes.
- R9: `rdData` shows the register at `rwAddr` combinationally, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srcA | input | NUM_SLOT | Primary event line of each slot |
| srcB | input | NUM_SLOT | Alternate event line of each slot |
| sampleStrobe | input | 1 | Instruction-boundary acceptance point |
| wrEn | input | 1 | Register write enable |
| rwAddr | input | 3 | Register address for read and write |
| wrData | input | NUM_SLOT | Register write data |
| rdData | output | NUM_SLOT | Register read data |
| accValid | output | 1 | One-cycle pulse: a slot was accepted |
| accVec | output | IDX_W | Binary index of the accepted slot |

## Verification
The properties assume that `sampleStrobe`, `wrEn` and the event lines are synchronous to `clk` and stable around the rising edge. They also assume that the event lines are held low while reset is applied, so no rising edge is seen on the first clock. The stimulus drives every input one nanosecond after the falling edge and keeps every line at 0 during reset. Random traffic therefore covers overlaps freely: strobes that coincide with writes to the mask flag or the pending register, line-select and polarity changes, and hardware sets in the same clock as a clear. All of these stay within the assumed synchronous timing.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PEND = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENAB = 3'd1;
  localparam logic [ADDR_W-1:0] A_POL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_LSEL = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd4;

  typedef struct packed {
    logic accept;
    logic ldPend;
    logic ldEnab;
    logic ldPol;
    logic ldLsel;
    logic ldMask;
  } irqStrobe_t;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_SLOT = 8,
  localparam int unsigned IDX_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic [NUM_SLOT-1:0] reqIn,
  output logic                anyReq,
  output logic [IDX_W-1:0]    winIdx
);

  always_comb begin
    anyReq = |reqIn;
    winIdx = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (reqIn[i]) winIdx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_req_pkg::*;
#(
  parameter int unsigned NUM_SLOT = 8,
  localparam int unsigned IDX_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleStrobe,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   rwAddr,
  input  logic [NUM_SLOT-1:0] pendVec,
  input  logic [NUM_SLOT-1:0] enabVec,
  input  logic                maskFlag,
  output irqStrobe_t          strobes,
  output logic [IDX_W-1:0]    winIdx,
  output logic                accValid,
  output logic [IDX_W-1:0]    accVec
);

  logic [NUM_SLOT-1:0] eligible;
  logic                anyElig;

  assign eligible = pendVec & enabVec & {NUM_SLOT{~maskFlag}};

  irq_prio_enc #(.NUM_SLOT(NUM_SLOT)) u_prio (
    .reqIn  (eligible),
    .anyReq (anyElig),
    .winIdx (winIdx)
  );

  always_comb begin
    strobes.accept = sampleStrobe & anyElig;
    strobes.ldPend = wrEn & (rwAddr == A_PEND);
    strobes.ldEnab = wrEn & (rwAddr == A_ENAB);
    strobes.ldPol  = wrEn & (rwAddr == A_POL);
    strobes.ldLsel = wrEn & (rwAddr == A_LSEL);
    strobes.ldMask = wrEn & (rwAddr == A_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accValid <= 1'b0;
      accVec   <= '0;
    end else begin
      accValid <= strobes.accept;
      if (strobes.accept) accVec <= winIdx;
    end
  end

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_req_pkg::*;
#(
  parameter int unsigned NUM_SLOT = 8,
  localparam int unsigned IDX_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SLOT-1:0] srcA,
  input  logic [NUM_SLOT-1:0] srcB,
  input  irqStrobe_t          strobes,
  input  logic [IDX_W-1:0]    winIdx,
  input  logic [ADDR_W-1:0]   rwAddr,
  input  logic [NUM_SLOT-1:0] wrData,
  output logic [NUM_SLOT-1:0] pendVec,
  output logic [NUM_SLOT-1:0] enabVec,
  output logic                maskFlag,
  output logic [NUM_SLOT-1:0] rdData
);

  logic [NUM_SLOT-1:0] polVec;
  logic [NUM_SLOT-1:0] lselVec;
  logic [NUM_SLOT-1:0] effLvl;
  logic [NUM_SLOT-1:0] effPrev;
  logic [NUM_SLOT-1:0] hwSet;
  logic [NUM_SLOT-1:0] accClr;
  logic [NUM_SLOT-1:0] swClr;

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    logic selLvl;
    assign selLvl    = lselVec[g] ? srcB[g] : srcA[g];
    assign effLvl[g] = selLvl ^ polVec[g];
    assign hwSet[g]  = effLvl[g] & ~effPrev[g];
    assign accClr[g] = strobes.accept & (winIdx == IDX_W'(g));
    assign swClr[g]  = strobes.ldPend & ~wrData[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        pendVec[g] <= 1'b0;
        effPrev[g] <= 1'b0;
      end else begin
        pendVec[g] <= (pendVec[g] & ~accClr[g] & ~swClr[g]) | hwSet[g];
        effPrev[g] <= effLvl[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enabVec  <= '0;
      polVec   <= '0;
      lselVec  <= '0;
      maskFlag <= 1'b1;
    end else begin
      if (strobes.ldEnab) enabVec <= wrData;
      if (strobes.ldPol)  polVec  <= wrData;
      if (strobes.ldLsel) lselVec <= wrData;
      if (strobes.accept)      maskFlag <= 1'b1;
      else if (strobes.ldMask) maskFlag <= wrData[0];
    end
  end

  always_comb begin
    case (rwAddr)
      A_PEND:  rdData = pendVec;
      A_ENAB:  rdData = enabVec;
      A_POL:   rdData = polVec;
      A_LSEL:  rdData = lselVec;
      A_MASK:  rdData = {{(NUM_SLOT-1){1'b0}}, maskFlag};
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl
  import irq_req_pkg::*;
#(
  parameter int unsigned NUM_SLOT = 8,
  localparam int unsigned IDX_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SLOT-1:0] srcA,
  input  logic [NUM_SLOT-1:0] srcB,
  input  logic                sampleStrobe,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   rwAddr,
  input  logic [NUM_SLOT-1:0] wrData,
  output logic [NUM_SLOT-1:0] rdData,
  output logic                accValid,
  output logic [IDX_W-1:0]    accVec
);

  irqStrobe_t          strobes;
  logic [IDX_W-1:0]    winIdx;
  logic [NUM_SLOT-1:0] pendVec;
  logic [NUM_SLOT-1:0] enabVec;
  logic                maskFlag;

  irq_ctrl #(.NUM_SLOT(NUM_SLOT)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .sampleStrobe (sampleStrobe),
    .wrEn         (wrEn),
    .rwAddr       (rwAddr),
    .pendVec      (pendVec),
    .enabVec      (enabVec),
    .maskFlag     (maskFlag),
    .strobes      (strobes),
    .winIdx       (winIdx),
    .accValid     (accValid),
    .accVec       (accVec)
  );

  irq_datapath #(.NUM_SLOT(NUM_SLOT)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .srcA     (srcA),
    .srcB     (srcB),
    .strobes  (strobes),
    .winIdx   (winIdx),
    .rwAddr   (rwAddr),
    .wrData   (wrData),
    .pendVec  (pendVec),
    .enabVec  (enabVec),
    .maskFlag (maskFlag),
    .rdData   (rdData)
  );

endmodule

// File: rtl/irq_req_ctrl_chk.sv
module irq_req_ctrl_chk #(
  parameter int unsigned NUM_SLOT = 8,
  localparam int unsigned IDX_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                sampleStrobe,
  input logic                accValid,
  input logic [IDX_W-1:0]    accVec,
  input logic [NUM_SLOT-1:0] pendVec,
  input logic [NUM_SLOT-1:0] enabVec,
  input logic                maskFlag
);

  logic [NUM_SLOT-1:0] winBit;
  logic [NUM_SLOT-1:0] lowerBits;

  assign winBit    = {{(NUM_SLOT-1){1'b0}}, 1'b1} << accVec;
  assign lowerBits = winBit - {{(NUM_SLOT-1){1'b0}}, 1'b1};

  p_accept_at_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    accValid |-> $past(sampleStrobe));

  p_masked_no_accept_r4: assert property (@(posedge clk) disable iff (rst)
    $past(maskFlag) |-> !accValid);

  p_winner_eligible_r4: assert property (@(posedge clk) disable iff (rst)
    accValid |-> (|($past(pendVec & enabVec) & winBit)));

  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (rst)
    accValid |-> (($past(pendVec & enabVec) & lowerBits) == '0));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    accValid |=> !accValid);

  p_mask_set_r6: assert property (@(posedge clk) disable iff (rst)
    accValid |-> maskFlag);

endmodule

bind irq_req_ctrl irq_req_ctrl_chk #(.NUM_SLOT(NUM_SLOT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sampleStrobe (sampleStrobe),
  .accValid     (accValid),
  .accVec       (accVec),
  .pendVec      (pendVec),
  .enabVec      (enabVec),
  .maskFlag     (maskFlag)
);

// File: tb/irq_req_ctrl_bench.sv
`timescale 1ns/1ps
module irq_req_ctrl_bench;

  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  srcA, srcB, wrData;
  logic          sampleStrobe, wrEn;
  logic [2:0]    rwAddr;
  logic [N-1:0]  rdData;
  logic          accValid;
  logic [IW-1:0] accVec;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  irq_req_ctrl #(.NUM_SLOT(N)) u_irq_req_ctrl (
    .clk(clk), .rst(rst), .srcA(srcA), .srcB(srcB),
    .sampleStrobe(sampleStrobe), .wrEn(wrEn), .rwAddr(rwAddr),
    .wrData(wrData), .rdData(rdData), .accValid(accValid), .accVec(accVec)
  );

  // reference state built from the requirements
  logic [N-1:0]  mPend, mEnab, mPol, mLsel, mPrev;
  logic          mMask, mAccV;
  logic [IW-1:0] mAccVec;

  function automatic logic [N-1:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mPend;
      3'd1: return mEnab;
      3'd2: return mPol;
      3'd3: return mLsel;
      3'd4: return {{(N-1){1'b0}}, mMask};
      default: return '0;
    endcase
  endfunction

  function automatic int lowestSet(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [N-1:0] eff, setv, elig, clr, nPend;
    logic acc;
    int idx;
    cycles++;
    if (rst) begin
      mPend = '0; mEnab = '0; mPol = '0; mLsel = '0; mPrev = '0;
      mMask = 1'b1; mAccV = 1'b0; mAccVec = '0;
    end else begin
      eff  = ((mLsel & srcB) | (~mLsel & srcA)) ^ mPol;
      setv = eff & ~mPrev;
      elig = mPend & mEnab & {N{~mMask}};
      acc  = sampleStrobe && (elig != '0);
      idx  = lowestSet(elig);
      clr  = (wrEn && rwAddr == 3'd0) ? ~wrData : '0;
      if (acc) clr[idx] = 1'b1;
      nPend = (mPend & ~clr) | setv;
      if (wrEn && rwAddr == 3'd1) mEnab = wrData;
      if (wrEn && rwAddr == 3'd2) mPol  = wrData;
      if (wrEn && rwAddr == 3'd3) mLsel = wrData;
      if (acc) mMask = 1'b1;
      else if (wrEn && rwAddr == 3'd4) mMask = wrData[0];
      mPend = nPend;
      mPrev = eff;
      mAccV = acc;
      if (acc) mAccVec = IW'(idx);
    end
  end

  // model comparison at every falling edge, inputs are moved 1 ns later
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R5 accValid", accValid, mAccV);
      if (mAccV) check("R5 accVec", accVec, mAccVec);
      case (rwAddr)
        3'd0:    check("R2 R7 pending read", rdData, expRead(rwAddr));
        3'd4:    check("R6 mask read", rdData, expRead(rwAddr));
        default: check("R8 register read", rdData, expRead(rwAddr));
      endcase
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  task automatic idle();
    @(negedge clk); #1;
    wrEn = 0; sampleStrobe = 0;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); #1;
    wrEn = 1; rwAddr = a; wrData = d; sampleStrobe = 0;
    @(negedge clk); #1;
    wrEn = 0;
  endtask

  initial begin
    rst = 1; srcA = '0; srcB = '0; wrData = '0; wrEn = 0;
    sampleStrobe = 0; rwAddr = 3'd0;
    repeat (3) @(negedge clk);
    #1 rst = 0;

    // R1 and R9: reset values, read back combinationally
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); #1 rwAddr = 3'(a);
      #0.5;
      check("R1 R9 reset read", rdData, (a == 4) ? 1 : 0);
    end
    check("R1 accValid after reset", accValid, 0);

    // R7: hardware set beats software clear on the same clock
    @(negedge clk); #1;
    wrEn = 1; rwAddr = 3'd0; wrData = '0; srcA[0] = 1'b1;
    @(negedge clk);
    check("R7 set over clear", rdData, 8'h01);
    #1 wrData = 8'hFF;
    @(negedge clk);
    check("R7 write one keeps", rdData, 8'h01);
    #1 wrData = 8'h00;
    @(negedge clk);
    check("R7 write zero clears", rdData, 8'h00);
    #1 wrEn = 0;

    // R3: select change and polarity change raise requests
    @(negedge clk); #1 srcB[2] = 1'b1;
    regWrite(3'd3, 8'h04);
    regWrite(3'd2, 8'h20);
    @(negedge clk); #1 rwAddr = 3'd0;
    @(negedge clk);
    check("R3 spurious pending", rdData, 8'h24);

    // R4: eligible but masked or without strobe
    regWrite(3'd1, 8'hFF);
    @(negedge clk); #1 sampleStrobe = 1;
    @(negedge clk);
    check("R4 masked strobe", accValid, 0);
    #1 sampleStrobe = 0;
    regWrite(3'd4, 8'h00);
    idle(); idle();
    check("R4 no strobe", accValid, 0);

    // R5/R6: lowest index first, mask set, loser kept
    @(negedge clk); #1 sampleStrobe = 1; rwAddr = 3'd0;
    @(negedge clk);
    check("R5 first accept", accValid, 1);
    check("R5 first vector", accVec, 2);
    check("R6 winner cleared", rdData, 8'h20);
    #1 sampleStrobe = 0; rwAddr = 3'd4;
    @(negedge clk);
    check("R5 one pulse", accValid, 0);
    check("R6 mask set", rdData, 1);

    // R6: accept overrides a same-clock write of 0 to the mask
    @(negedge clk); #1 wrEn = 1; rwAddr = 3'd4; wrData = '0;
    @(negedge clk); #1 wrEn = 1; sampleStrobe = 1;
    @(negedge clk);
    check("R6 accept second", accVec, 5);
    check("R6 mask wins", rdData, 1);
    #1 wrEn = 0; sampleStrobe = 0;

    // R8: unused addresses ignore writes
    regWrite(3'd6, 8'hFF);
    @(negedge clk); #1 rwAddr = 3'd6;
    #0.5 check("R8 unused address", rdData, 0);

    // random traffic checked against the model
    void'($urandom(32'h1D5C_0042));
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); #1;
      if ($urandom_range(3) == 0) srcA = srcA ^ N'($urandom);
      if ($urandom_range(3) == 0) srcB = srcB ^ N'($urandom);
      sampleStrobe = ($urandom_range(2) == 0);
      wrEn = ($urandom_range(3) == 0);
      rwAddr = 3'($urandom_range(7));
      wrData = N'($urandom);
      if (wrEn && rwAddr == 3'd0 && $urandom_range(1) == 0) wrData = '0;
    end
    idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule